// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Controller

This block resolves read-after-write dependencies in the execute stage of a five-stage, 32-bit load/store pipeline without stalling. It compares the two source register numbers of the instruction now in execute against the destination register numbers of the two older instructions still in flight. One of these sits in the memory-stage pipeline register and the other in the write-back pipeline register. For each ALU operand it produces a 2-bit select and applies it to a three-way operand multiplexer. The operand can come from the register-file value carried with the instruction, from the memory-stage result register, or from the write-back value.

A second path serves a store that directly follows a load of the same register. The store-data multiplexer in the memory stage can take the write-back value in place of the store's own carried data, so the copy runs back to back. A store whose address depends on the loaded register is a load-use hazard. That case is left to the stall logic outside this block. Every output is combinational, and the block holds no state.

Top module: `exec_bypass_unit`

## Requirements
- R1: Operand A select is 2'b10 (memory-stage result) whenever the memory stage writes a register, its destination is non-zero, and that destination equals the execute-stage first source number.
- R2: Operand B select is 2'b10 under the same test applied to the execute-stage second source number.
- R3: Operand A select is 2'b01 (write-back value) when write-back writes a register, its destination is non-zero and equals the first source, and the memory-stage destination field differs from the first source. The last condition holds even if the memory stage is not writing.
- R4: Operand B select is 2'b01 under the same test applied to the second source.
- R5: When both later stages would supply the same source register, the select is 2'b10, so the newer result wins.
- R6: A source register number of 0 always gives select 2'b00 (register-file value), whatever the later stages hold.
- R7: A stage whose write flag is low never supplies an operand.
- R8: Each ALU operand output equals the carried register value for select 2'b00, the memory-stage result for 2'b10 and the write-back value for 2'b01. Select 2'b11 is never produced.
- R9: The store-data select is 1 only when the memory-stage instruction is a store, write-back writes a register, and the write-back destination is non-zero and equals the store's second source. The store-data output is then the write-back value; otherwise it is the store's carried data.
- R10: All outputs follow their inputs within the same cycle, with no clock edge between stimulus and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | 5 | First source register number of the instruction in execute |
| ex_rt_i | input | 5 | Second source register number of the instruction in execute |
| ex_rs_val_i | input | 32 | Register-file value carried for the first source |
| ex_rt_val_i | input | 32 | Register-file value carried for the second source |
| mem_rd_i | input | 5 | Destination register number in the memory-stage register |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_result_i | input | 32 | Result held in the memory-stage register |
| mem_is_store_i | input | 1 | Memory-stage instruction is a store |
| mem_rt_i | input | 5 | Second source register number of the memory-stage store |
| mem_store_val_i | input | 32 | Store data carried in the memory-stage register |
| wb_rd_i | input | 5 | Destination register number in the write-back register |
| wb_we_i | input | 1 | Write-back instruction writes a register |
| wb_value_i | input | 32 | Value being written back |
| fwd_a_sel_o | output | 2 | Operand A select |
| fwd_b_sel_o | output | 2 | Operand B select |
| alu_a_o | output | 32 | Selected operand A |
| alu_b_o | output | 32 | Selected operand B |
| store_sel_o | output | 1 | Store-data bypass select |
| store_data_o | output | 32 | Selected data-memory write data |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages on any path. The bench applies each stimulus on the falling clock edge and samples 2 ns later, before any rising edge could matter. One directed step changes the inputs in the middle of the high phase and samples again without any edge, to show that the outputs do not wait for the clock. Expected selects come from a vector table written from the requirements. Expected data values are derived from those selects using distinct data patterns for each source.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned REG_NUM_W = 5;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_OPND  = 2;

  typedef enum logic [1:0] {
    SEL_REG = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int unsigned RW = REG_NUM_W
) (
  input  logic [RW-1:0] src_i,
  input  logic [RW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [RW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output fwd_sel_e      sel_o
);
  logic mem_hit;
  logic wb_hit;

  always_comb begin
    mem_hit = mem_we_i && (|mem_rd_i) && (mem_rd_i == src_i);
    wb_hit  = wb_we_i && (|wb_rd_i) && (wb_rd_i == src_i) && (mem_rd_i != src_i);
    if (mem_hit)     sel_o = SEL_MEM;
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_REG;
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] reg_val_i,
  input  logic [DW-1:0] mem_val_i,
  input  logic [DW-1:0] wb_val_i,
  output logic [DW-1:0] opnd_o
);
  always_comb begin
    case (sel_i)
      SEL_MEM: opnd_o = mem_val_i;
      SEL_WB:  opnd_o = wb_val_i;
      default: opnd_o = reg_val_i;
    endcase
  end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel
  import fwd_pkg::*;
#(
  parameter int unsigned RW = REG_NUM_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          is_store_i,
  input  logic [RW-1:0] store_rt_i,
  input  logic [DW-1:0] store_val_i,
  input  logic [RW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  input  logic [DW-1:0] wb_val_i,
  output logic          sel_o,
  output logic [DW-1:0] data_o
);
  always_comb begin
    sel_o  = is_store_i && wb_we_i && (|wb_rd_i) && (wb_rd_i == store_rt_i);
    data_o = sel_o ? wb_val_i : store_val_i;
  end
endmodule

// File: rtl/exec_bypass_unit.sv
module exec_bypass_unit
  import fwd_pkg::*;
#(
  parameter int unsigned RW = REG_NUM_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic [RW-1:0] ex_rs_i,
  input  logic [RW-1:0] ex_rt_i,
  input  logic [DW-1:0] ex_rs_val_i,
  input  logic [DW-1:0] ex_rt_val_i,
  input  logic [RW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [DW-1:0] mem_result_i,
  input  logic          mem_is_store_i,
  input  logic [RW-1:0] mem_rt_i,
  input  logic [DW-1:0] mem_store_val_i,
  input  logic [RW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  input  logic [DW-1:0] wb_value_i,
  output logic [1:0]    fwd_a_sel_o,
  output logic [1:0]    fwd_b_sel_o,
  output logic [DW-1:0] alu_a_o,
  output logic [DW-1:0] alu_b_o,
  output logic          store_sel_o,
  output logic [DW-1:0] store_data_o
);
  logic     [RW-1:0] src     [NUM_OPND];
  logic     [DW-1:0] reg_val [NUM_OPND];
  fwd_sel_e          sel     [NUM_OPND];
  logic     [DW-1:0] opnd    [NUM_OPND];

  assign src[0]     = ex_rs_i;
  assign src[1]     = ex_rt_i;
  assign reg_val[0] = ex_rs_val_i;
  assign reg_val[1] = ex_rt_val_i;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    fwd_operand_sel #(.RW(RW)) u_sel (
      .src_i    (src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel[g])
    );
    fwd_operand_mux #(.DW(DW)) u_mux (
      .sel_i     (sel[g]),
      .reg_val_i (reg_val[g]),
      .mem_val_i (mem_result_i),
      .wb_val_i  (wb_value_i),
      .opnd_o    (opnd[g])
    );
  end

  fwd_store_sel #(.RW(RW), .DW(DW)) u_store (
    .is_store_i  (mem_is_store_i),
    .store_rt_i  (mem_rt_i),
    .store_val_i (mem_store_val_i),
    .wb_rd_i     (wb_rd_i),
    .wb_we_i     (wb_we_i),
    .wb_val_i    (wb_value_i),
    .sel_o       (store_sel_o),
    .data_o      (store_data_o)
  );

  assign fwd_a_sel_o = sel[0];
  assign fwd_b_sel_o = sel[1];
  assign alu_a_o     = opnd[0];
  assign alu_b_o     = opnd[1];

  always_comb begin
    assert_sel_legal_R8: assert (fwd_a_sel_o != 2'b11 && fwd_b_sel_o != 2'b11);
    assert_a_mem_data_R8: assert (fwd_a_sel_o != SEL_MEM || alu_a_o == mem_result_i);
    assert_b_wb_data_R8: assert (fwd_b_sel_o != SEL_WB || alu_b_o == wb_value_i);
    assert_newest_wins_R5: assert (!(mem_we_i && (|mem_rd_i) && mem_rd_i == ex_rs_i)
                                   || fwd_a_sel_o == SEL_MEM);
    assert_zero_src_R6: assert (ex_rs_i != '0 || fwd_a_sel_o == SEL_REG);
    assert_idle_stages_R7: assert (mem_we_i || wb_we_i
                                   || (fwd_a_sel_o == SEL_REG && fwd_b_sel_o == SEL_REG));
    assert_store_data_R9: assert (!store_sel_o || store_data_o == wb_value_i);
    assert_store_only_R9: assert (mem_is_store_i || !store_sel_o);
  end
endmodule

// File: tb/tb_exec_bypass_unit.sv
module tb_exec_bypass_unit;
  logic clk;
  logic [4:0]  ex_rs, ex_rt, mem_rd, mem_rt, wb_rd;
  logic [31:0] rs_val, rt_val, mem_res, store_val, wb_val;
  logic        mem_we, mem_st, wb_we;
  logic [1:0]  a_sel, b_sel;
  logic [31:0] alu_a, alu_b, st_data;
  logic        st_sel;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  exec_bypass_unit dut (
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .ex_rs_val_i(rs_val), .ex_rt_val_i(rt_val),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_result_i(mem_res),
    .mem_is_store_i(mem_st), .mem_rt_i(mem_rt), .mem_store_val_i(store_val),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we), .wb_value_i(wb_val),
    .fwd_a_sel_o(a_sel), .fwd_b_sel_o(b_sel), .alu_a_o(alu_a), .alu_b_o(alu_b),
    .store_sel_o(st_sel), .store_data_o(st_data)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // fields: rs, rt, mem_rd, mem_we, wb_rd, wb_we, exp_a, exp_b
  localparam int NV = 11;
  localparam logic [25:0] VECS [NV] = '{
    {5'd0,  5'd0,  5'd0,  1'b0, 5'd0,  1'b0, 2'b00, 2'b00},  // idle
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00},  // R1
    {5'd5,  5'd3,  5'd3,  1'b1, 5'd0,  1'b0, 2'b00, 2'b10},  // R2
    {5'd7,  5'd8,  5'd9,  1'b1, 5'd7,  1'b1, 2'b01, 2'b00},  // R3
    {5'd2,  5'd6,  5'd1,  1'b0, 5'd6,  1'b1, 2'b00, 2'b01},  // R4
    {5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'b10, 2'b10},  // R5
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00},  // R6
    {5'd4,  5'd4,  5'd4,  1'b0, 5'd4,  1'b0, 2'b00, 2'b00},  // R7
    {5'd10, 5'd11, 5'd10, 1'b0, 5'd10, 1'b1, 2'b00, 2'b00},  // R3 blocked by mem field
    {5'd12, 5'd13, 5'd13, 1'b1, 5'd12, 1'b1, 2'b01, 2'b10},  // R3 and R2 mixed
    {5'd31, 5'd31, 5'd0,  1'b1, 5'd31, 1'b1, 2'b01, 2'b01}   // R4 top register
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] r);
    if (s == 2'b10) return mem_res;
    if (s == 2'b01) return wb_val;
    return r;
  endfunction

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    ex_rs = 0; ex_rt = 0; mem_rd = 0; mem_rt = 0; wb_rd = 0;
    mem_we = 0; mem_st = 0; wb_we = 0;
    rs_val = 32'hA5A5_0001; rt_val = 32'hB4B4_0002; mem_res = 32'hC3C3_0003;
    store_val = 32'hD2D2_0004; wb_val = 32'hE1E1_0005;
    @(negedge clk); #2;
    // reset-like idle state: nothing forwarded
    chk(a_sel == 2'b00 && b_sel == 2'b00 && !st_sel, "R7 idle", {a_sel, b_sel}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VECS[i];
      @(negedge clk);
      {ex_rs, ex_rt, mem_rd, mem_we, wb_rd, wb_we} = v[25:4];
      #2;
      chk(a_sel == v[3:2], $sformatf("R1/R3 selA vec%0d", i), 32'(a_sel), 32'(v[3:2]));
      chk(b_sel == v[1:0], $sformatf("R2/R4 selB vec%0d", i), 32'(b_sel), 32'(v[1:0]));
      chk(alu_a == pick(v[3:2], rs_val), $sformatf("R8 dataA vec%0d", i),
          alu_a, pick(v[3:2], rs_val));
      chk(alu_b == pick(v[1:0], rt_val), $sformatf("R8 dataB vec%0d", i),
          alu_b, pick(v[1:0], rt_val));
    end

    // R9: store bypass hit
    @(negedge clk);
    mem_st = 1; mem_rt = 5'd9; wb_rd = 5'd9; wb_we = 1; #2;
    chk(st_sel && st_data == wb_val, "R9 hit", st_data, wb_val);
    // R9: not a store
    mem_st = 0; #2;
    chk(!st_sel && st_data == store_val, "R9 not store", st_data, store_val);
    // R9: destination zero
    mem_st = 1; mem_rt = 0; wb_rd = 0; #2;
    chk(!st_sel && st_data == store_val, "R9 zero reg", st_data, store_val);
    // R9: write flag low
    mem_rt = 5'd9; wb_rd = 5'd9; wb_we = 0; #2;
    chk(!st_sel && st_data == store_val, "R9 no write", st_data, store_val);
    // R9: register mismatch
    wb_we = 1; wb_rd = 5'd8; #2;
    chk(!st_sel && st_data == store_val, "R9 mismatch", st_data, store_val);

    // R10: change inputs inside high phase, sample with no edge in between
    @(posedge clk); #2;
    ex_rs = 5'd20; mem_rd = 5'd20; mem_we = 1; mem_res = 32'h1234_5678; #1;
    chk(a_sel == 2'b10 && alu_a == 32'h1234_5678, "R10 same cycle", alu_a, 32'h1234_5678);
    mem_we = 0; wb_rd = 5'd20; #1;
    chk(a_sel == 2'b00 && alu_a == rs_val, "R10 follow, R3 mem field block", alu_a, rs_val);
    mem_rd = 5'd1; #1;
    chk(a_sel == 2'b01 && alu_a == wb_val, "R10 follow wb", alu_a, wb_val);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule